// File: doc/BRIEF.md
# Integer Execute Unit with Overflow Trap

This block is the integer execute stage of a load-store processor core. On each issued operation it takes two register operands, a raw 16-bit immediate field, a 4-bit operation code and a flag that selects the immediate in place of the second register operand. It returns a result word, a write-enable for the destination register and an overflow-exception flag. All three outputs are registered and appear one clock after issue.

The unit covers modular and trapping add and subtract, the four bitwise operations, signed and unsigned set-on-less-than, the three shifts, and load-upper-immediate. It widens the immediate itself. Compare and add-class operations sign-extend it, and bitwise operations zero-extend it. An overflow on a trapping add or subtract raises the exception flag and drops the write-enable in the same cycle, so the destination register is left unchanged.

Operation codes: 0 ADD (trapping), 1 ADDU, 2 SUB (trapping), 3 SUBU, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 SLT, 9 SLTU, 10 SLL, 11 SRL, 12 SRA, 13 LUI.

Top module: `alu_exec`

## Requirements
- R1: Codes 0 and 1 return (a + b) mod 2^32, and codes 2 and 3 return (a - b) mod 2^32, where b is the register operand or the widened immediate.
- R2: Codes 0 and 2 assert `exc_ovf_o` when the two's-complement result does not fit in 32 bits. In that same cycle `wr_en_o` is low.
- R3: Codes 1 and 3 and all other codes never assert `exc_ovf_o`. An issued operation without overflow asserts `wr_en_o`.
- R4: With `use_imm_i`=1, codes 0, 1, 2, 3, 8 and 9 use the immediate sign-extended to 32 bits, with bit 15 copied upward.
- R5: Codes 4, 5, 6 and 7 return a&b, a|b, a^b and ~(a|b). With `use_imm_i`=1 the immediate is zero-extended.
- R6: Code 8 returns 1 if a < b as signed values, otherwise 0. Code 9 compares natural numbers, so all-ones is greater than 1. Bits 31:1 of the result are zero.
- R7: Code 13 returns the immediate in bits 31:16 and zeros in bits 15:0. The register operands are ignored.
- R8: Codes 10, 11 and 12 shift `opa_i` left, logically right or arithmetically right. An arithmetic shift fills with bit 31 of `opa_i`. The amount is `imm_i[10:6]` when `use_imm_i`=1. Otherwise it is `opb_i[4:0]`, and bits 31:5 of `opb_i` are ignored.
- R9: Outputs reflect the operation issued on the previous clock edge. A cycle with `issue_i` low gives `wr_en_o`=0 and `exc_ovf_o`=0 on the next cycle and leaves `result_o` unchanged.
- R10: While `rst_n` is low, `result_o`, `wr_en_o` and `exc_ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is issued this cycle |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Use the immediate as the second operand or shift amount |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Raw immediate field |
| result_o | output | 32 | Result of the last issued operation |
| wr_en_o | output | 1 | Destination write-enable |
| exc_ovf_o | output | 1 | Overflow exception |

## Verification
Overflow detection and write-enable suppression happen in the same cycle. A missing or late suppression would let a trapping add corrupt the destination. The bench provokes this with trapping adds and subtracts at the signed boundaries (0x7fffffff + 1, 0x80000000 - 1, and similar pairs) drawn from an operand sweep. It also uses sign-extended immediates whose bit 15 is set. For each such case it requires `exc_ovf_o` high and `wr_en_o` low on the same sampled cycle. It requires the opposite pair for the modular forms given the same operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13
    } alu_op_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              sext_i,
    output logic [DATA_W-1:0] ext_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        ext_o = {{PAD_W{sext_i & imm_i[IMM_W-1]}}, imm_i};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o,
    output logic              lt_s_o,
    output logic              lt_u_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_inv;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_inv  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_inv} + {{DATA_W{1'b0}}, sub_i};
        sum_o  = wide[MSB:0];
        // operands agree in sign (after inversion) but the sum does not
        ovf_o  = (a_i[MSB] == b_inv[MSB]) && (sum_o[MSB] != a_i[MSB]);
        // in subtract mode a carry out means a >= b unsigned
        lt_u_o = ~wide[DATA_W];
        lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [SH_W-1:0]   amt_i,
    input  logic              left_i,
    input  logic              arith_i,
    output logic [DATA_W-1:0] out_o
);
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] stage [SH_W+1];
    logic              fill;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) rev_in[i] = val_i[DATA_W-1-i];
        fill = arith_i & ~left_i & val_i[DATA_W-1];
    end

    assign stage[0] = left_i ? rev_in : val_i;

    // one right-shift stage per amount bit; left shifts run reversed
    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            assign stage[k+1] = amt_i[k]
                ? {{DIST{fill}}, stage[k][DATA_W-1:DIST]}
                : stage[k];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            out_o[i] = left_i ? stage[SH_W][DATA_W-1-i] : stage[SH_W][i];
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec #(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 16,
    parameter int SHAMT_LO = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [3:0]        op_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              exc_ovf_o
);
    import alu_pkg::*;

    localparam int SH_W  = $clog2(DATA_W);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic              is_logic, is_sub, is_left, is_arith, trap_op;
    logic [DATA_W-1:0] imm_ext, b_eff, sum, shifted, res_d;
    logic [SH_W-1:0]   shamt;
    logic              ovf_raw, lt_s, lt_u, trap;

    always_comb begin
        op       = alu_op_e'(op_i);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
        is_sub   = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
        is_left  = (op == OP_SLL);
        is_arith = (op == OP_SRA);
        trap_op  = (op == OP_ADD) || (op == OP_SUB);
        b_eff    = use_imm_i ? imm_ext : opb_i;
        shamt    = use_imm_i ? imm_i[SHAMT_LO +: SH_W] : opb_i[SH_W-1:0];
    end

    alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_i  (imm_i),
        .sext_i (~is_logic),
        .ext_o  (imm_ext)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_add (
        .a_i    (opa_i),
        .b_i    (b_eff),
        .sub_i  (is_sub),
        .sum_o  (sum),
        .ovf_o  (ovf_raw),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
        .val_i   (opa_i),
        .amt_i   (shamt),
        .left_i  (is_left),
        .arith_i (is_arith),
        .out_o   (shifted)
    );

    always_comb begin
        res_d = '0;
        unique case (op)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU:        res_d = sum;
            OP_AND:                 res_d = opa_i & b_eff;
            OP_OR:                  res_d = opa_i | b_eff;
            OP_XOR:                 res_d = opa_i ^ b_eff;
            OP_NOR:                 res_d = ~(opa_i | b_eff);
            OP_SLT:                 res_d = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU:                res_d = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA: res_d = shifted;
            OP_LUI:                 res_d = {imm_i, {LOW_W{1'b0}}};
            default:                res_d = '0;
        endcase
        trap = trap_op & ovf_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            wr_en_o   <= 1'b0;
            exc_ovf_o <= 1'b0;
        end else begin
            wr_en_o   <= issue_i & ~trap;
            exc_ovf_o <= issue_i & trap;
            if (issue_i) result_o <= res_d;
        end
    end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [3:0]        op_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              exc_ovf_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    AST_OVF_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ovf_o |-> !wr_en_o); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i != 4'd0 && op_i != 4'd2) |=> (!exc_ovf_o && wr_en_o)); // R3

    AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == 4'd8 || op_i == 4'd9)) |=> (result_o[DATA_W-1:1] == '0)); // R6

    AST_LUI_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == 4'd13) |=>
        (result_o[LOW_W-1:0] == '0 && result_o[DATA_W-1:LOW_W] == $past(imm_i))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && !exc_ovf_o)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && $past(rst_n)) |=> $stable(result_o)); // R9
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (issue_i),
    .op_i      (op_i),
    .imm_i     (imm_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .exc_ovf_o (exc_ovf_o)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic        exc_ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_exec u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .use_imm_i(use_imm_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .exc_ovf_o(exc_ovf_o)
    );

    function automatic logic [31:0] pick_word(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hffff_ffff;
            3: return 32'h7fff_ffff;
            4: return 32'h8000_0000;
            5: return 32'h1234_5678;
            6: return 32'hfedc_ba98;
            default: return 32'hffff_ffe3; // low 5 bits 3, upper bits set
        endcase
    endfunction

    function automatic logic [15:0] pick_imm(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hffff;
            3: return 16'h7fff;
            4: return 16'h8000;
            5: return 16'h0440; // bits 10:6 = 17
            6: return 16'ha5c3;
            default: return 16'h07c0; // bits 10:6 = 31
        endcase
    endfunction

    function automatic string req_of(input int op, input bit imm);
        if (imm && (op <= 3 || op == 8 || op == 9)) return "R4";
        if (op <= 3) return "R1";
        if (op <= 7) return "R5";
        if (op <= 9) return "R6";
        if (op <= 12) return "R8";
        return "R7";
    endfunction

    // expected values from plain arithmetic on wide signed integers
    task automatic model(input int op, input bit imm, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] iv,
                         output logic [31:0] res, output bit ovf);
        logic [31:0] bb;
        longint sa, sb, wide;
        int sh;
        bb = b;
        if (imm) begin
            if (op >= 4 && op <= 7) bb = {16'h0000, iv};
            else bb = {{16{iv[15]}}, iv};
        end
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        sh = imm ? int'(iv[10:6]) : int'(b[4:0]);
        ovf = 1'b0;
        res = '0;
        case (op)
            0, 1: begin wide = sa + sb; res = a + bb;
                        ovf = (op == 0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
            2, 3: begin wide = sa - sb; res = a - bb;
                        ovf = (op == 2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
            4: res = a & bb;
            5: res = a | bb;
            6: res = a ^ bb;
            7: res = ~(a | bb);
            8: res = (sa < sb) ? 32'd1 : 32'd0;
            9: res = ({32'd0, a} < {32'd0, bb}) ? 32'd1 : 32'd0;
            10: res = a << sh;
            11: res = a >> sh;
            12: begin wide = sa >>> sh; res = wide[31:0]; end
            default: res = {iv, 16'h0000};
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int op, input bit imm, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] iv);
        logic [31:0] er;
        bit eo;
        model(op, imm, a, b, iv, er, eo);
        @(negedge clk);
        issue_i = 1'b1; op_i = 4'(op); use_imm_i = imm;
        opa_i = a; opb_i = b; imm_i = iv;
        @(negedge clk);
        check(req_of(op, imm), $sformatf("result op=%0d", op), result_o, er);
        check(eo ? "R2" : "R3", $sformatf("ovf op=%0d", op), {31'd0, exc_ovf_o}, {31'd0, eo});
        check(eo ? "R2" : "R3", $sformatf("wen op=%0d", op), {31'd0, wr_en_o}, {31'd0, !eo});
    endtask

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "result", result_o, 32'd0);
        check("R10", "wen", {31'd0, wr_en_o}, 32'd0);
        check("R10", "ovf", {31'd0, exc_ovf_o}, 32'd0);
        rst_n = 1'b1;

        for (int op = 0; op < 14; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    run_op(op, 1'b0, pick_word(i), pick_word(j), pick_imm(j));
                    run_op(op, 1'b1, pick_word(i), pick_word(j), pick_imm(j));
                end

        // R2: named boundary overflows
        run_op(0, 1'b0, 32'h7fff_ffff, 32'h0000_0001, 16'h0);
        run_op(2, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0);
        run_op(0, 1'b1, 32'h8000_0000, 32'h0, 16'hffff);
        // R3: same operands, modular forms
        run_op(1, 1'b0, 32'h7fff_ffff, 32'h0000_0001, 16'h0);
        run_op(3, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0);

        // R9: idle cycle holds result and drops flags
        run_op(5, 1'b0, 32'hdead_0000, 32'h0000_beef, 16'h0);
        held = result_o;
        @(negedge clk);
        issue_i = 1'b0; opa_i = 32'h1111_1111; op_i = 4'd0;
        @(negedge clk);
        check("R9", "idle result", result_o, held);
        check("R9", "idle wen", {31'd0, wr_en_o}, 32'd0);
        check("R9", "idle ovf", {31'd0, exc_ovf_o}, 32'd0);
        // R9: overflow followed by idle clears the flag
        run_op(0, 1'b0, 32'h7fff_ffff, 32'h7fff_ffff, 16'h0);
        @(negedge clk);
        issue_i = 1'b0;
        @(negedge clk);
        check("R9", "ovf clears", {31'd0, exc_ovf_o}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule